// File: doc/BRIEF.md
# Sequential Unsigned Binary Divider

This block divides an unsigned dividend by an unsigned divisor that is half as wide. It produces a quotient and a remainder, each as wide as the divisor. The default widths are an 8-bit dividend and a 4-bit divisor. All the work happens in one working register that is one bit wider than the dividend and shifts left. Each new quotient bit is written into the least significant position, which a shift has just emptied. When the operation ends, the lower half of the register holds the quotient and the half above it holds the remainder.

A compare-and-subtract unit looks at the upper divisor-width-plus-one bits of the working register. When that field is at least the divisor, the difference replaces the field and a quotient one is recorded. When it is smaller, nothing is subtracted and the register only shifts, so no restore step is ever needed. The operands are checked right after they are loaded. If the top half of the dividend is already at least the divisor, the quotient would not fit, so the block raises its overflow flag and stops at once. A zero divisor always takes this path.

A one-cycle start pulse begins an operation. A one-cycle done pulse marks its end. The results and the overflow flag stay steady until the next accepted start.

Top module: `seq_divider`

## Requirements
- R1: After reset, done and overflow are 0.
- R2: When the upper half of the dividend is below the divisor, the quotient at done equals the integer part of dividend divided by divisor.
- R3: Under the same condition, the remainder at done equals dividend modulo divisor, and it is always below the divisor.
- R4: When the upper half of the dividend is at least the divisor, done is asserted with overflow = 1, two clock edges after the edge that sampled start. Otherwise overflow = 0 at done.
- R5: A divisor of zero is always reported as overflow.
- R6: done is high for exactly one cycle per operation.
- R7: Without overflow, done is asserted 6 + k clock edges after the edge that sampled start. Here k is the number of ones among quotient bits 3, 2 and 1: each subtraction except the last costs one extra shift cycle, and a subtraction is never followed directly by another compare.
- R8: start, dividend and divisor have no effect while an operation is in progress. The results of the running operation are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when the block is idle |
| dividend | input | 8 | Unsigned dividend, sampled with start |
| divisor | input | 4 | Unsigned divisor, sampled with start |
| quotient | output | 4 | Quotient, valid from done |
| remainder | output | 4 | Remainder, valid from done |
| overflow | output | 1 | Quotient would not fit, or the divisor is zero |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The assertions take for granted that start is a synchronous signal sampled on the rising edge. They also take for granted that the operands matter only in the cycle when an idle block accepts start. The stimulus drives every input on the falling edge. It raises start only from idle, except for deliberate pulses in the middle of an operation, which carry unrelated operands and test R8. The random operands draw the divisor from its whole range, zero included. As a result, both overflow and normal divisions come up often, next to directed cases at the edges of the quotient range.

// File: rtl/div_pkg.sv
package div_pkg;

    // One-hot controller state positions
    localparam int ST_IDLE = 0;
    localparam int ST_CHK  = 1;
    localparam int ST_CMP  = 2;
    localparam int ST_SHF  = 3;
    localparam int ST_FIN  = 4;
    localparam int NSTATE  = 5;

    typedef logic [NSTATE-1:0] state_t;

    // Commands from the controller to the datapath
    typedef struct packed {
        logic load;
        logic shift;
        logic sub;
        logic flag_ovf;
    } dcmd_t;

    function automatic state_t one_state(input int pos);
        state_t s;
        s = '0;
        s[pos] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/div_datapath.sv
module div_datapath #(
    parameter int DW = 8,
    parameter int QW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  div_pkg::dcmd_t  cmd,
    input  logic [DW-1:0]   dividend,
    input  logic [QW-1:0]   divisor,
    output logic [DW:0]     work,
    output logic            ge
);
    localparam int XW = DW + 1;
    localparam int UW = XW - QW;

    logic [XW-1:0] x_q;
    logic [QW-1:0] dvs_q;
    logic [UW-1:0] upper;
    logic [UW-1:0] dvs_ext;
    logic [UW-1:0] diff;

    assign upper   = x_q[XW-1:QW];
    assign dvs_ext = {{(UW-QW){1'b0}}, dvs_q};
    assign diff    = upper - dvs_ext;
    assign ge      = (upper >= dvs_ext);
    assign work    = x_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            dvs_q <= '0;
        end else if (cmd.load) begin
            x_q   <= {1'b0, dividend};
            dvs_q <= divisor;
        end else if (cmd.sub) begin
            x_q[XW-1:QW] <= diff;
            x_q[0]       <= 1'b1;
        end else if (cmd.shift) begin
            x_q <= {x_q[XW-2:0], 1'b0};
        end
    end

    // R3
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.sub |=> (x_q[XW-1:QW] < {{(UW-QW){1'b0}}, dvs_q}));

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl #(
    parameter int QW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           ge,
    output div_pkg::dcmd_t cmd,
    output logic           ovf,
    output logic           done
);
    import div_pkg::*;

    localparam int CW = $clog2(QW + 1);

    state_t        st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(QW));
    assign done = st_q[ST_FIN];

    always_comb begin
        st_d = '0;
        cmd  = '0;
        if (st_q[ST_IDLE]) begin
            if (start) begin
                cmd.load = 1'b1;
                st_d     = one_state(ST_CHK);
            end else begin
                st_d = one_state(ST_IDLE);
            end
        end else if (st_q[ST_CHK]) begin
            if (ge) begin
                cmd.flag_ovf = 1'b1;
                st_d         = one_state(ST_FIN);
            end else begin
                cmd.shift = 1'b1;
                st_d      = one_state(ST_CMP);
            end
        end else if (st_q[ST_CMP]) begin
            if (ge) begin
                cmd.sub = 1'b1;
                st_d    = last ? one_state(ST_FIN) : one_state(ST_SHF);
            end else if (last) begin
                st_d = one_state(ST_FIN);
            end else begin
                cmd.shift = 1'b1;
                st_d      = one_state(ST_CMP);
            end
        end else if (st_q[ST_SHF]) begin
            cmd.shift = 1'b1;
            st_d      = one_state(ST_CMP);
        end else begin
            st_d = one_state(ST_IDLE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= one_state(ST_IDLE);
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (cmd.load) begin
                cnt_q <= '0;
                ovf   <= 1'b0;
            end else begin
                if (cmd.shift)    cnt_q <= cnt_q + 1'b1;
                if (cmd.flag_ovf) ovf   <= 1'b1;
            end
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    sub_then_shift_chk: assert property (@(posedge clk) disable iff (rst)
        st_q[ST_SHF] |-> !ge);

    // R7
    state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(st_q) == 1);

    // R4
    ovf_decide_chk: assert property (@(posedge clk) disable iff (rst)
        st_q[ST_CHK] |=> (ovf == $past(ge)));

endmodule

// File: rtl/seq_divider.sv
module seq_divider (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] dividend,
    input  logic [3:0] divisor,
    output logic [3:0] quotient,
    output logic [3:0] remainder,
    output logic       overflow,
    output logic       done
);
    localparam int DW = 8;
    localparam int QW = 4;

    div_pkg::dcmd_t cmd;
    logic [DW:0]    work;
    logic           ge;

    div_ctrl #(.QW(QW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ge    (ge),
        .cmd   (cmd),
        .ovf   (overflow),
        .done  (done)
    );

    div_datapath #(.DW(DW), .QW(QW)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .dividend (dividend),
        .divisor  (divisor),
        .work     (work),
        .ge       (ge)
    );

    assign quotient  = work[QW-1:0];
    assign remainder = work[2*QW-1:QW];

    // R5
    zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.load && divisor == '0) |=> ##1 (overflow && done));

endmodule

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] dividend = '0;
    logic [3:0] divisor = '0;
    logic [3:0] quotient, remainder;
    logic       overflow, done;

    int checks = 0;
    int errors = 0;
    int seed_v = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_divider u0 (
        .clk(clk), .rst(rst), .start(start),
        .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .remainder(remainder),
        .overflow(overflow), .done(done)
    );

    function automatic bit exp_ovf(input int a, input int b);
        return (b == 0) || ((a >> 4) >= b);
    endfunction

    function automatic int exp_lat(input int a, input int b);
        int q;
        if (exp_ovf(a, b)) return 1;
        q = a / b;
        return 5 + ((q >> 3) & 1) + ((q >> 2) & 1) + ((q >> 1) & 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int a, input int b, input bit inject);
        int n;
        bit ov;
        ov = exp_ovf(a, b);
        @(negedge clk);
        dividend = 8'(a);
        divisor  = 4'(b);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (inject && n == 2) begin
                start    = 1'b1;
                dividend = 8'($urandom);
                divisor  = 4'($urandom);
            end
            if (inject && n == 3) start = 1'b0;
        end
        // R7 and R4: latency to done
        chk(n == exp_lat(a, b), ov ? "R4 latency" : "R7 latency", n, exp_lat(a, b));
        if (b == 0) chk(overflow == 1'b1, "R5 zero divisor", overflow, 1);
        else        chk(overflow == ov, "R4 overflow flag", overflow, int'(ov));
        if (!ov) begin
            chk(quotient == 4'(a / b), inject ? "R8 quotient" : "R2 quotient", quotient, a / b);
            chk(remainder == 4'(a % b), inject ? "R8 remainder" : "R3 remainder", remainder, a % b);
        end
        @(negedge clk);
        // R6: single-cycle done
        chk(done == 1'b0, "R6 done pulse", done, 0);
    endtask

    initial begin
        int watchdog;
        watchdog = 0;
        while (watchdog < 150000) begin
            @(posedge clk);
            watchdog++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", watchdog, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        seed_v = $urandom(1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(done == 1'b0, "R1 done", done, 0);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);

        run(239, 15, 1'b0);   // R2 quotient 15
        run(15, 1, 1'b0);     // R2 max quotient, small dividend
        run(0, 5, 1'b0);      // R3 zero dividend
        run(127, 8, 1'b0);    // R3
        run(200, 13, 1'b0);   // R2
        run(255, 15, 1'b0);   // R4 overflow at top
        run(16, 1, 1'b0);     // R4 overflow boundary
        run(77, 0, 1'b0);     // R5
        run(0, 0, 1'b0);      // R5
        run(100, 9, 1'b1);    // R8
        run(238, 15, 1'b1);   // R8

        for (int i = 0; i < 80; i++) begin
            int a, b;
            a = int'($urandom_range(0, 255));
            b = int'($urandom_range(0, 15));
            if (i % 2 == 0 && b != 0) a = a % (b * 16);
            run(a, b, (i % 5 == 0) && !exp_ovf(a, b));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule